// File: doc/BRIEF.md
# Synchronous Burst Read Sequencer

This block is the read-path controller of a NOR flash array. It leaves reset in asynchronous page mode. An address-valid strobe latches a start address. After a fixed initial delay, the word at that address is presented. After that, any word of the same aligned eight-word page can be picked with the three low address bits, one clock after they change.

When the read configuration register is written, the block switches to clocked synchronous bursts. A strobe latches the start address, and the block waits a programmable first-access latency. An internal address counter then steps, and one word is presented per burst beat. Each word is held for one or two clocks. Bursts are eight or sixteen words with wrap inside the aligned group, or they run linearly up to the top of the address space. A WAIT output with programmable polarity marks every clock on which a burst is open and no data is valid. The array sits outside the block as a synchronous memory with a one-clock read latency.

Top module: `burst_read_seq`

## Requirements
- R1: After reset the block is in asynchronous page mode, `dout_valid` is low and `wait_o` is low. Synchronous bursts start only after a write on `cfg_we`, and a later reset returns the block to page mode.
- R2: Configuration word fields: bits 14:11 are the latency code, bit 10 is the WAIT polarity (1 means active high), bit 9 selects two-clock data hold, bit 7 enables wrap, and bits 2:0 are the burst length. The other bits are ignored.
- R3: In a synchronous burst, the first word is valid exactly L clock edges after the edge that samples `adv`. L is the latency code when it lies between 2 and MAX_LAT; every other code gives L = MAX_LAT.
- R4: Words follow the start address in ascending order. Each word stays on `dout` for two clocks when bit 9 is set and for one clock when it is clear.
- R5: With bit 7 set and a length code of 3'b010 (8 words) or 3'b011 (16 words), the address increments only within the aligned group of that size and wraps to its base.
- R6: Without wrap, or with length code 3'b111 or any other code (continuous), the burst runs up to the all-ones address. After that word's hold time, no further data is valid.
- R7: During synchronous mode with `rd_en` high, `wait_o` sits at its active level exactly on the clocks where `dout_valid` is low. Otherwise `wait_o` sits at its inactive level.
- R8: Dropping `rd_en` ends the access: `dout_valid` is low after the next clock edge.
- R9: In page mode the word at the latched start address is valid PAGE_LAT edges after the strobe. When `addr_in[2:0]` changes, `dout_valid` goes low at once and shows the new word of the latched page after one edge. Upper address bits are ignored until the next strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Writes `cfg_data` into the read configuration |
| cfg_data | input | 16 | Read configuration word |
| rd_en | input | 1 | Read access enable; low ends any access |
| adv | input | 1 | Address-valid strobe |
| addr_in | input | AW | Word address |
| mem_addr | output | AW | Address to the array |
| mem_rdata | input | DW | Array data, one clock after `mem_addr` |
| dout | output | DW | Read data |
| dout_valid | output | 1 | `dout` holds valid data |
| wait_o | output | 1 | WAIT indication, polarity from configuration |

## Verification
The bench builds the block with AW = 6, MAX_LAT = 7 and PAGE_LAT = 3. With a 64-word space, continuous and non-wrapping bursts reach the all-ones address and stop within a few dozen clocks, so the end-of-space case comes up in both directed and random runs. The small latency ceiling lets every latency code, including the reserved ones, be swept quickly. The short page delay keeps page-mode checks short.

// File: rtl/burst_read_seq.sv
module burst_read_seq #(
  parameter int AW       = 8,
  parameter int DW       = 16,
  parameter int MAX_LAT  = 7,
  parameter int PAGE_LAT = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [15:0]   cfg_data,
  input  logic          rd_en,
  input  logic          adv,
  input  logic [AW-1:0] addr_in,
  output logic [AW-1:0] mem_addr,
  input  logic [DW-1:0] mem_rdata,
  output logic [DW-1:0] dout,
  output logic          dout_valid,
  output logic          wait_o
);
  localparam logic [3:0] LAT_MAX4  = 4'(MAX_LAT);
  localparam logic [3:0] PAGE_LD   = 4'(PAGE_LAT - 1);
  localparam logic [AW-1:0] MASK8  = AW'(7);
  localparam logic [AW-1:0] MASK16 = AW'(15);

  logic          sync_q, wp_q, dh_q, wrap_q;
  logic [3:0]    lc_q, lat_q;
  logic [2:0]    bl_q, lo_q;
  logic [AW-1:0] addr_q;
  logic          active_q, valid_q, ph_q, end_q;

  wire unused_cfg = ^{cfg_data[15], cfg_data[8], cfg_data[6:3]};

  wire [3:0]    lat_eff   = (lc_q < 4'd2 || lc_q > LAT_MAX4) ? LAT_MAX4 : lc_q;
  wire          is16      = (bl_q == 3'b011);
  wire          do_wrap   = wrap_q && (bl_q == 3'b010 || is16);
  wire [AW-1:0] grp_mask  = is16 ? MASK16 : MASK8;
  wire [AW-1:0] inc_addr  = addr_q + AW'(1);
  wire [AW-1:0] next_addr = do_wrap ? ((addr_q & ~grp_mask) | (inc_addr & grp_mask)) : inc_addr;
  wire          at_top    = &addr_q;

  wire starting = sync_q && active_q && (!valid_q ? (lat_q == 4'd0) : (!ph_q && !end_q));
  wire stepping = starting ? !dh_q : (sync_q && active_q && valid_q && ph_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q <= 1'b0; lc_q <= 4'd7; wp_q <= 1'b1; dh_q <= 1'b1;
      wrap_q <= 1'b0; bl_q <= 3'b111;
      addr_q <= '0; lat_q <= '0; lo_q <= '0;
      active_q <= 1'b0; valid_q <= 1'b0; ph_q <= 1'b0; end_q <= 1'b0;
    end else begin
      lo_q <= addr_in[2:0];
      if (cfg_we) begin
        sync_q <= 1'b1;
        lc_q   <= cfg_data[14:11];
        wp_q   <= cfg_data[10];
        dh_q   <= cfg_data[9];
        wrap_q <= cfg_data[7];
        bl_q   <= cfg_data[2:0];
        active_q <= 1'b0; valid_q <= 1'b0;
      end else if (!rd_en) begin
        active_q <= 1'b0; valid_q <= 1'b0;
      end else if (adv) begin
        addr_q   <= addr_in;
        active_q <= 1'b1; valid_q <= 1'b0;
        ph_q     <= 1'b0; end_q <= 1'b0;
        lat_q    <= sync_q ? (lat_eff - 4'd1) : PAGE_LD;
      end else if (active_q) begin
        if (!valid_q) begin
          if (lat_q != 4'd0) lat_q <= lat_q - 4'd1;
          else begin valid_q <= 1'b1; ph_q <= dh_q; end
        end else if (sync_q) begin
          if (ph_q) ph_q <= 1'b0;
          else if (end_q) begin valid_q <= 1'b0; active_q <= 1'b0; end
          else ph_q <= dh_q;
        end
        if (stepping) begin
          if (!do_wrap && at_top) end_q <= 1'b1;
          else addr_q <= next_addr;
        end
      end
    end
  end

  assign mem_addr   = sync_q ? addr_q : {addr_q[AW-1:3], addr_in[2:0]};
  assign dout       = mem_rdata;
  assign dout_valid = valid_q && (sync_q || addr_in[2:0] == lo_q);
  assign wait_o     = (sync_q && rd_en && !dout_valid) ? wp_q : ~wp_q;

  a_r1_page_wait_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_q |-> (wait_o == ~wp_q));

  a_r4_step_one: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_q && active_q && rd_en && !adv && !cfg_we && !do_wrap)
      |=> (addr_q == $past(addr_q)) || (addr_q == $past(addr_q) + AW'(1)));

  a_r4_hold_two: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_q && dh_q && rd_en && !adv && !cfg_we && $rose(valid_q)) |=> valid_q);

  a_r5_wrap_group: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_q && active_q && rd_en && !adv && !cfg_we && do_wrap)
      |=> ((addr_q | grp_mask) == ($past(addr_q) | grp_mask)));

  a_r7_wait_level: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_q && rd_en) |-> ((wait_o == wp_q) != dout_valid));
endmodule

// File: tb/sim_burst_read_seq.sv
module sim_burst_read_seq;
  localparam int AW = 6;
  localparam int DW = 16;
  localparam int MAXL = 7;
  localparam int PL = 3;
  localparam int TOP = (1 << AW) - 1;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, cfg_we, rd_en, adv, dout_valid, wait_o;
  logic [15:0] cfg_data;
  logic [AW-1:0] addr_in, mem_addr;
  logic [DW-1:0] mem_rdata, dout;
  int checks = 0, fails = 0;
  bit done = 0;

  burst_read_seq #(.AW(AW), .DW(DW), .MAX_LAT(MAXL), .PAGE_LAT(PL)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_data(cfg_data), .rd_en(rd_en),
    .adv(adv), .addr_in(addr_in), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .dout(dout), .dout_valid(dout_valid), .wait_o(wait_o));

  function automatic logic [15:0] memf(input int a);
    logic [15:0] x;
    x = 16'(a & TOP);
    return (x * 16'd40503) ^ 16'h5A3C;
  endfunction

  always @(posedge clk) mem_rdata <= memf(int'(mem_addr));

  function automatic int exp_lat(input int lc);
    return (lc < 2 || lc > MAXL) ? MAXL : lc;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; cfg_we = 0; adv = 0; rd_en = 1; addr_in = '0; cfg_data = '0;
    @(negedge clk); @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic run_sync(input int lc, input bit wp, input bit dh, input bit wr,
                          input int bl, input int a, input int ncyc);
    int L, w, ea, m;
    bit ev, wrapping;
    cfg_data = 16'((lc << 11) | (int'(wp) << 10) | (int'(dh) << 9) | (int'(wr) << 7) | bl);
    cfg_we = 1;
    @(negedge clk);
    cfg_we = 0; adv = 1; rd_en = 1; addr_in = AW'(a);
    @(negedge clk);
    adv = 0; addr_in = AW'($urandom);
    L = exp_lat(lc);
    wrapping = wr && (bl == 2 || bl == 3);
    m = (bl == 3) ? 15 : 7;
    for (int k = 0; k < ncyc; k++) begin
      ev = 0; ea = 0;
      if (k >= L) begin
        w = (k - L) / (dh ? 2 : 1);
        if (wrapping) begin ev = 1; ea = (a & ~m) | ((a + w) & m); end
        else if (a + w <= TOP) begin ev = 1; ea = a + w; end
      end
      chk(dout_valid == ev, "R2 R3 R6 valid", int'(dout_valid), int'(ev));
      chk(wait_o == (ev ? !wp : wp), "R7 wait level", int'(wait_o), int'(ev ? !wp : wp));
      if (ev) chk(dout == memf(ea), "R4 R5 data", int'(dout), int'(memf(ea)));
      @(negedge clk);
    end
  endtask

  task automatic page_read(input int a, input int b);
    int hi;
    hi = a & ~7;
    adv = 1; rd_en = 1; addr_in = AW'(a);
    @(negedge clk);
    adv = 0;
    for (int k = 0; k < PL; k++) begin
      chk(dout_valid == 0, "R9 page delay", int'(dout_valid), 0);
      @(negedge clk);
    end
    chk(dout_valid == 1 && dout == memf(a), "R9 first page word", int'(dout), int'(memf(a)));
    chk(wait_o == 0, "R1 wait idle in page mode", int'(wait_o), 0);
    addr_in = AW'(hi | b);
    #1;
    chk(dout_valid == 0, "R9 low bits changed", int'(dout_valid), 0);
    @(negedge clk);
    chk(dout_valid == 1 && dout == memf(hi | b), "R9 page word", int'(dout), int'(memf(hi | b)));
    addr_in = AW'((~hi & TOP & ~7) | b);
    @(negedge clk);
    chk(dout_valid == 1 && dout == memf(hi | b), "R9 upper bits ignored", int'(dout), int'(memf(hi | b)));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    summary();
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 0; cfg_we = 0; adv = 0; rd_en = 1; addr_in = '0; cfg_data = '0;
    do_reset();
    chk(dout_valid == 0, "R1 reset valid", int'(dout_valid), 0);
    chk(wait_o == 0, "R1 reset wait", int'(wait_o), 0);
    page_read(6'h13, 6);
    page_read(6'h2F, 0);

    run_sync(2, 1, 0, 0, 7, 6'h05, 20);
    run_sync(0, 1, 1, 0, 7, 6'h10, 30);
    run_sync(15, 0, 0, 0, 2, 6'h20, 30);
    run_sync(1, 1, 0, 0, 7, 6'h00, 12);
    run_sync(3, 1, 0, 1, 2, 6'h0E, 30);
    run_sync(4, 0, 1, 1, 2, 6'h0E, 40);
    run_sync(2, 1, 0, 1, 3, 6'h1D, 40);
    run_sync(5, 1, 1, 1, 3, 6'h33, 50);
    run_sync(3, 1, 0, 0, 2, 6'h3C, 20);
    run_sync(2, 0, 1, 0, 7, 6'h3D, 20);
    run_sync(6, 1, 0, 1, 5, 6'h3A, 20);

    run_sync(2, 1, 0, 0, 7, 6'h08, 5);
    rd_en = 0;
    @(negedge clk);
    chk(dout_valid == 0, "R8 rd_en low ends burst", int'(dout_valid), 0);
    chk(wait_o == 0, "R8 R7 wait inactive with rd_en low", int'(wait_o), 0);
    rd_en = 1;

    for (int i = 0; i < 30; i++) begin
      int bls[4] = '{2, 3, 7, 4};
      run_sync(int'($urandom_range(15)), bit'($urandom_range(1)), bit'($urandom_range(1)),
               bit'($urandom_range(1)), bls[$urandom_range(3)], int'($urandom_range(TOP)), 48);
    end

    run_sync(2, 1, 0, 0, 7, 6'h01, 4);
    do_reset();
    chk(dout_valid == 0 && wait_o == 0, "R1 reset returns to page mode", int'(wait_o), 0);
    page_read(6'h21, 3);
    summary();
  end
endmodule